// File: doc/BRIEF.md
# Edge-Select Interrupt Latch Unit

This block captures events on two asynchronous pins, a horizontal sync input and a power-control input, and turns each into a held request toward a processor core. Each pin has its own sticky latch. The latch sets on the edge chosen for that channel, either rising or falling. It stays set until software clears it. Each latch drives an active-low interrupt line. A per-channel enable can force that line inactive (high) without disturbing the latch.

Software configures both channels through a single write-only control byte. In that byte, two positions for each channel are stored settings: the trigger edge and the interrupt enable. A third position is a clear strobe. The strobe acts only in the cycle of the write and is never stored, so every clear needs a fresh write with that bit at 1. The sync channel's latch can also be read back as one bit of an 8-bit status word. The power channel's latch is visible only through its interrupt line.

Top module: `edge_irq_latch_unit`

## Requirements
- R1: Synchronous reset clears both latches and all stored settings. After reset both interrupt outputs are 1 and `status_rdata` is 8'h00.
- R2: With the channel's edge bit at 1, a 0-to-1 transition of its pin sets the latch, and a 1-to-0 transition leaves the latch unchanged. The edge bits are write-data bit 1 for sync and bit 4 for power.
- R3: With the channel's edge bit at 0, a 1-to-0 transition of its pin sets the latch. Changing the edge bit while the pin is steady sets nothing.
- R4: A write with the clear bit at 1 clears that channel's latch. The clear bits are bit 3 for sync and bit 6 for power. The clear is not retained: a later qualifying edge sets the latch again, and it stays set until another clear write.
- R5: An interrupt output is 0 exactly when its latch is set and its enable bit is 1. The enable bits are bit 2 for sync and bit 5 for power. Clearing the enable drives the output to 1 and keeps the latch. Setting the enable again drives the output back to 0.
- R6: `status_rdata` bit 3 equals the sync latch state, independent of the enable. All other status bits read 0.
- R7: The two channels are independent. A clear, an edge or a setting on one channel does not change the other channel's latch or output.
- R8: When a clear write and a qualifying edge reach a latch in the same cycle, the latch ends up set.
- R9: Write-data bits 0 and 7 have no effect on any output.
- R10: A pin transition launched before clock edge E1 updates the status bit after edge E3 and drives the interrupt output low after edge E4. The output is still high after E3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| hsync_pin | input | 1 | Asynchronous horizontal sync pin |
| pwr_pin | input | 1 | Asynchronous power-control pin |
| hsync_irq_n | output | 1 | Active-low sync interrupt request |
| pwr_irq_n | output | 1 | Active-low power interrupt request |
| status_rdata | output | 8 | Status word; bit 3 is the sync latch |

## Verification
If a latch fails to set or fails to clear, the status bit shows it three cycles after the pin moves, and the interrupt line shows it one cycle later. A wrong stored enable or edge setting appears only when the next event occurs. For that reason the stimulus toggles each setting while the latches are both set and clear, and while the pins are steady. The same-cycle clear-versus-edge race and the four-cycle pin-to-output latency are aimed at exactly, so that an extra or missing register in the path moves a result past the point where it is sampled.

// File: rtl/elu_pkg.sv
package elu_pkg;

  // Control byte geometry: channel c owns bits BASE + 3*c .. +2
  localparam int CTRL_W      = 8;
  localparam int CH_BASE     = 1;
  localparam int CH_STRIDE   = 3;
  localparam int OFS_EDGE    = 0;
  localparam int OFS_EN      = 1;
  localparam int OFS_CLR     = 2;

  // Status word geometry
  localparam int STAT_W      = 8;
  localparam int STAT_HS_BIT = 3;

  typedef struct packed {
    logic rise_sel;  // 1: rising edge sets, 0: falling edge sets
    logic irq_en;    // 1: interrupt line follows latch
  } chan_cfg_t;

  function automatic int bit_pos(input int ch, input int ofs);
    return CH_BASE + CH_STRIDE * ch + ofs;
  endfunction

endpackage

// File: rtl/elu_sync_edge.sv
module elu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise =  sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/elu_ctrl_reg.sv
module elu_ctrl_reg
  import elu_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output chan_cfg_t [NCH-1:0] cfg_q,
  output logic [NCH-1:0]    clr_stb
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int P_EDGE = bit_pos(c, OFS_EDGE);
    localparam int P_EN   = bit_pos(c, OFS_EN);
    localparam int P_CLR  = bit_pos(c, OFS_CLR);

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[c] <= '0;
      end else if (we) begin
        cfg_q[c].rise_sel <= wdata[P_EDGE];
        cfg_q[c].irq_en   <= wdata[P_EN];
      end
    end

    // Strobe exists only during the write cycle
    assign clr_stb[c] = we & wdata[P_CLR];
  end

endmodule

// File: rtl/elu_latch_chan.sv
module elu_latch_chan
  import elu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rise,
  input  logic      fall,
  input  chan_cfg_t cfg,
  input  logic      clr,
  output logic      set_pulse,
  output logic      latch_q,
  output logic      irq_n_q
);

  assign set_pulse = cfg.rise_sel ? rise : fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
    end else if (set_pulse) begin
      latch_q <= 1'b1;   // edge beats a simultaneous clear
    end else if (clr) begin
      latch_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~(cfg.irq_en & latch_q);
  end

endmodule

// File: rtl/edge_irq_latch_unit.sv
module edge_irq_latch_unit
  import elu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              hsync_pin,
  input  logic              pwr_pin,
  output logic              hsync_irq_n,
  output logic              pwr_irq_n,
  output logic [STAT_W-1:0] status_rdata
);

  localparam int NCH = 2;

  logic [NCH-1:0]       pins;
  logic [NCH-1:0]       rise;
  logic [NCH-1:0]       fall;
  logic [NCH-1:0]       clr_stb;
  logic [NCH-1:0]       set_pulse;
  logic [NCH-1:0]       latch_q;
  logic [NCH-1:0]       irq_n_q;
  chan_cfg_t [NCH-1:0]  cfg_q;

  assign pins = {pwr_pin, hsync_pin};

  elu_ctrl_reg #(.NCH(NCH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl_we),
    .wdata   (ctrl_wdata),
    .cfg_q   (cfg_q),
    .clr_stb (clr_stb)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    elu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin  (pins[c]),
      .rise (rise[c]),
      .fall (fall[c])
    );

    elu_latch_chan u_latch (
      .clk       (clk),
      .rst       (rst),
      .rise      (rise[c]),
      .fall      (fall[c]),
      .cfg       (cfg_q[c]),
      .clr       (clr_stb[c]),
      .set_pulse (set_pulse[c]),
      .latch_q   (latch_q[c]),
      .irq_n_q   (irq_n_q[c])
    );
  end

  assign hsync_irq_n = irq_n_q[0];
  assign pwr_irq_n   = irq_n_q[1];

  always_comb begin
    status_rdata              = '0;
    status_rdata[STAT_HS_BIT] = latch_q[0];
  end

endmodule

// File: rtl/elu_checker.sv
module elu_checker (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_we,
  input logic [7:0] ctrl_wdata,
  input logic       hsync_irq_n,
  input logic       pwr_irq_n,
  input logic [7:0] status_rdata,
  input logic       hs_set,
  input logic       pw_set,
  input logic       pw_latch
);

  AST_HS_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    hs_set |=> status_rdata[3]);                                            // R8

  AST_HS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata[3] && !hs_set) |=> !status_rdata[3]);            // R4

  AST_HS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status_rdata[3] && !(ctrl_we && ctrl_wdata[3])) |=> status_rdata[3]);  // R4

  AST_HS_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !status_rdata[3] |=> hsync_irq_n);                                      // R5

  AST_PW_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pw_latch |=> pwr_irq_n);                                               // R5

  AST_PW_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    pw_set |=> pw_latch);                                                   // R2

endmodule

bind edge_irq_latch_unit elu_checker u_elu_checker (
  .clk          (clk),
  .rst          (rst),
  .ctrl_we      (ctrl_we),
  .ctrl_wdata   (ctrl_wdata),
  .hsync_irq_n  (hsync_irq_n),
  .pwr_irq_n    (pwr_irq_n),
  .status_rdata (status_rdata),
  .hs_set       (set_pulse[0]),
  .pw_set       (set_pulse[1]),
  .pw_latch     (latch_q[1])
);

// File: tb/test_edge_irq_latch_unit.sv
module test_edge_irq_latch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic       we;
    logic [7:0] wd;
    logic       hs;
    logic       pw;
    logic       eh;   // expected hsync_irq_n
    logic       ep;   // expected pwr_irq_n
    logic [7:0] es;   // expected status
    logic [3:0] req;
  } vec_t;

  // 0x36: both rising, both enabled. Clear bits: 3 (sync), 6 (power).
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h36, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 4'd5},  // R5 enable, idle
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h08, 4'd2},  // R2 rise sets
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h08, 4'd2},  // R2 fall ignored
    '{1'b1, 8'h3E, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 4'd4},  // R4 clear sync
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h08, 4'd4},  // R4 sets again
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h08, 4'd7},  // R7 power sets
    '{1'b1, 8'h3E, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 4'd7},  // R7 sync clear only
    '{1'b1, 8'h16, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 4'd5},  // R5 power disabled
    '{1'b1, 8'h36, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 4'd5},  // R5 re-enabled
    '{1'b1, 8'h76, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 4'd4},  // R4 clear power
    '{1'b1, 8'h24, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 4'd3},  // R3 select change
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h08, 4'd3},  // R3 sync fall
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08, 4'd3},  // R3 power fall
    '{1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08, 4'd9},  // R9 spare bits
    '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h08, 4'd6},  // R6 status w/o enable
    '{1'b1, 8'h48, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 4'd4}   // R4 clear both
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       hsync_pin = 1'b0;
  logic       pwr_pin = 1'b0;
  logic       hsync_irq_n;
  logic       pwr_irq_n;
  logic [7:0] status_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_latch_unit i_edge_irq_latch_unit (
    .clk          (clk),
    .rst          (rst),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .hsync_pin    (hsync_pin),
    .pwr_pin      (pwr_pin),
    .hsync_irq_n  (hsync_irq_n),
    .pwr_irq_n    (pwr_irq_n),
    .status_rdata (status_rdata)
  );

  task automatic check(input string req, input logic eh, input logic ep,
                       input logic [7:0] es);
    n_checks++;
    if (hsync_irq_n !== eh || pwr_irq_n !== ep || status_rdata !== es) begin
      n_fails++;
      $display("FAIL %s: got hirq=%b pirq=%b stat=%h, expected hirq=%b pirq=%b stat=%h",
               req, hsync_irq_n, pwr_irq_n, status_rdata, eh, ep, es);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] d);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
    ctrl_wdata = 8'h00;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", 1'b1, 1'b1, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      hsync_pin = VECS[i].hs;
      pwr_pin   = VECS[i].pw;
      if (VECS[i].we) begin
        ctrl_we    = 1'b1;
        ctrl_wdata = VECS[i].wd;
      end
      @(negedge clk);
      ctrl_we    = 1'b0;
      ctrl_wdata = 8'h00;
      repeat (5) @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].eh, VECS[i].ep, VECS[i].es);
    end

    // R8: clear write and rising edge hit the latch at the same clock edge
    write_ctrl(8'h06);
    @(negedge clk);
    hsync_pin = 1'b1;
    repeat (2) @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = 8'h0E;
    @(negedge clk);
    ctrl_we = 1'b0;
    ctrl_wdata = 8'h00;
    repeat (3) @(negedge clk);
    check("R8 edge wins over clear", 1'b0, 1'b1, 8'h08);

    write_ctrl(8'h0E);
    check("R4 clear after race", 1'b1, 1'b1, 8'h00);

    // R10: falling-edge latency, pin moved before E1
    write_ctrl(8'h04);
    hsync_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 after third edge", 1'b1, 1'b1, 8'h08);
    @(negedge clk);
    check("R10 after fourth edge", 1'b0, 1'b1, 8'h08);

    // R1: reset in mid-run with a latch set
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset", 1'b1, 1'b1, 8'h00);
    repeat (4) @(negedge clk);
    check("R1 quiet after reset", 1'b1, 1'b1, 8'h00);

    finish_run();
  end

endmodule